// File: doc/BRIEF.md
# DSP Barrel Shifter Unit

This block is the shift and bit-manipulation unit of a 32-bit fixed-point DSP datapath. Each cycle it may accept one operation: a 32-bit operand, a signed shift amount, a field position and length, a deposit target word, and a 4-bit opcode. It computes the result in one pass of combinational logic and registers it together with a zero flag and an overflow flag. The result is therefore ready on the next cycle for any other unit.

The operations are logical shift, arithmetic shift, rotate, single-bit set, clear, toggle and test, bit-field extract, bit-field deposit, and derive-exponent. Derive-exponent counts the redundant sign bits of the operand and returns that count negated, for use in normalisation. There is no internal pipeline. An accepted operation always produces its registered result one clock later.

Top module: `shifter_unit`

## Requirements
- R1: An operation accepted with `in_valid` high appears on `result`, `zero_flag` and `ovf_flag` with `out_valid` high exactly one clock later. A cycle with `in_valid` low gives `out_valid` low on the next cycle and leaves `result` and the flags unchanged.
- R2: Opcode 0 (logical shift): a non-negative `amount` shifts left and a negative `amount` shifts right, with zero fill in both directions. A magnitude of 32 or more gives zero.
- R3: Opcode 1 (arithmetic shift): left shifts behave as in R2. Right shifts fill with the sign bit (bit 31). A right magnitude of 32 or more gives all copies of the sign bit.
- R4: Opcode 2 (rotate): the operand rotates left by `amount` modulo 32. A negative amount therefore rotates right by its magnitude.
- R5: Opcodes 3, 4 and 5 set, clear and toggle the single operand bit indexed by `fpos[4:0]`. All other bits stay unchanged.
- R6: Opcode 6 (bit test): the result is 1 when operand bit `fpos[4:0]` is set and 0 otherwise. Result bits 31:1 are always zero.
- R7: Opcode 7 (extract): the result is the `flen`-bit field of the operand whose lowest bit is at `fpos`, right-justified and zero-filled. Field bits above bit 31 read as zero. A length of 0 gives 0, and a length of 32 or more takes every remaining bit.
- R8: Opcode 8 (deposit): the low `flen` bits of the operand replace `target` bits starting at `fpos`. All other `target` bits pass unchanged, and field bits that would land above bit 31 are dropped.
- R9: Opcode 9 (derive exponent): the result is the negated count of operand bits below bit 31 that match bit 31 before the first differing bit, as a two's-complement value. Examples: 0x40000000 gives 0, 0x00000001 gives -30, and 0 or 0xFFFFFFFF gives -31.
- R10: `zero_flag` is set exactly when the registered result is zero.
- R11: `ovf_flag` is set only for opcodes 0 and 1 with a non-negative `amount` when at least one set operand bit is shifted out past bit 31. It is clear for all other operations and for right shifts.
- R12: While `rst` is high on a clock edge, the next cycle shows `out_valid`, `result`, `zero_flag` and `ovf_flag` all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation present this cycle |
| op | input | 4 | Opcode (0..9, see requirements) |
| operand | input | 32 | Source word |
| amount | input | 8 | Signed shift/rotate amount |
| fpos | input | 6 | Bit index or field start position |
| flen | input | 6 | Field length |
| target | input | 32 | Word that receives a deposited field |
| out_valid | output | 1 | Registered result is new this cycle |
| result | output | 32 | Registered result |
| zero_flag | output | 1 | Result equals zero |
| ovf_flag | output | 1 | Left shift lost a set bit |

## Verification
Shifts are tried with positive, negative, exactly-32, large negative (-40 and -128) and sign-bit-set operands. These separate the left and right paths, zero fill from sign fill, and the out-of-range saturation from a wrapped amount. The field operations use fields wholly inside the word, fields running past bit 31, zero length and full length, which tell correct masking apart from off-by-one or wrap-around errors. Derive-exponent uses operands with 0, 1, 30 and 31 redundant sign bits of both signs. An idle stretch then shows that the registered result holds.

// File: rtl/shf_pkg.sv
package shf_pkg;

    localparam int DATA_W = 32;
    localparam int AMT_W  = 8;
    localparam int POS_W  = 6;
    localparam int OP_W   = 4;
    localparam int SH_W   = $clog2(DATA_W);
    localparam int CNT_W  = SH_W + 1;

    typedef enum logic [OP_W-1:0] {
        OP_LSH  = 4'd0,
        OP_ASH  = 4'd1,
        OP_ROT  = 4'd2,
        OP_BSET = 4'd3,
        OP_BCLR = 4'd4,
        OP_BTGL = 4'd5,
        OP_BTST = 4'd6,
        OP_FEXT = 4'd7,
        OP_FDEP = 4'd8,
        OP_EXP  = 4'd9
    } shf_op_e;

    typedef struct packed {
        logic [DATA_W-1:0] value;
        logic              zero;
        logic              ovf;
    } shf_res_t;

    // Low-order mask of len ones; len >= DATA_W yields all ones.
    function automatic logic [DATA_W-1:0] field_mask(input logic [POS_W-1:0] len);
        logic [DATA_W:0] t;
        t = ({{DATA_W{1'b0}}, 1'b1} << len) - 1'b1;
        return t[DATA_W-1:0];
    endfunction

endpackage

// File: rtl/shf_shift_core.sv
module shf_shift_core #(
    parameter int W  = 32,
    parameter int AW = 8
) (
    input  logic [W-1:0]  operand,
    input  logic [AW-1:0] amount,
    input  logic          arith,
    input  logic          rotate,
    output logic [W-1:0]  value,
    output logic          lost
);
    localparam int SW = $clog2(W);

    logic          neg;
    logic [AW:0]   ext;
    logic [AW:0]   mag;
    logic          big;
    logic [2*W-1:0] wide;
    logic [2*W-1:0] rot;
    logic          fill;

    always_comb begin
        neg  = amount[AW-1];
        ext  = {amount[AW-1], amount};
        mag  = neg ? (~ext + 1'b1) : ext;
        big  = (mag >= (AW+1)'(W));
        wide = {{W{1'b0}}, operand} << mag[SW-1:0];
        rot  = {operand, operand} << amount[SW-1:0];
        fill = arith & operand[W-1];
        lost = 1'b0;
        if (rotate) begin
            value = rot[2*W-1:W];
        end else if (!neg) begin
            value = big ? '0 : wide[W-1:0];
            lost  = big ? (|operand) : (|wide[2*W-1:W]);
        end else if (big) begin
            value = {W{fill}};
        end else if (arith) begin
            value = W'($signed(operand) >>> mag[SW-1:0]);
        end else begin
            value = operand >> mag[SW-1:0];
        end
    end
endmodule

// File: rtl/shf_bitfield.sv
module shf_bitfield
    import shf_pkg::*;
#(
    parameter int W  = 32,
    parameter int PW = 6
) (
    input  shf_op_e        op,
    input  logic [W-1:0]   operand,
    input  logic [W-1:0]   target,
    input  logic [PW-1:0]  fpos,
    input  logic [PW-1:0]  flen,
    output logic [W-1:0]   value
);
    localparam int SW = $clog2(W);

    logic [W-1:0]   onehot;
    logic [W-1:0]   mask;
    logic [2*W-1:0] ext_w;
    logic [2*W-1:0] dmask_w;
    logic [2*W-1:0] dbits_w;

    always_comb begin
        onehot  = W'(1) << fpos[SW-1:0];
        mask    = field_mask(flen);
        ext_w   = {{W{1'b0}}, operand} >> fpos;
        dmask_w = {{W{1'b0}}, mask} << fpos;
        dbits_w = {{W{1'b0}}, operand & mask} << fpos;
        unique case (op)
            OP_BSET: value = operand | onehot;
            OP_BCLR: value = operand & ~onehot;
            OP_BTGL: value = operand ^ onehot;
            OP_BTST: value = W'(|(operand & onehot));
            OP_FEXT: value = ext_w[W-1:0] & mask;
            OP_FDEP: value = (target & ~dmask_w[W-1:0]) | dbits_w[W-1:0];
            default: value = operand;
        endcase
    end
endmodule

// File: rtl/shf_exp_count.sv
module shf_exp_count #(
    parameter int W = 32
) (
    input  logic [W-1:0] operand,
    output logic [W-1:0] value
);
    localparam int CW = $clog2(W) + 1;

    logic [CW-1:0] red;
    logic          run;

    always_comb begin
        red = '0;
        run = 1'b1;
        for (int i = W - 2; i >= 0; i--) begin
            if (run && (operand[i] == operand[W-1])) begin
                red = red + CW'(1);
            end else begin
                run = 1'b0;
            end
        end
        value = '0 - W'(red);
    end
endmodule

// File: rtl/shifter_unit.sv
module shifter_unit
    import shf_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [OP_W-1:0]   op,
    input  logic [DATA_W-1:0] operand,
    input  logic [AMT_W-1:0]  amount,
    input  logic [POS_W-1:0]  fpos,
    input  logic [POS_W-1:0]  flen,
    input  logic [DATA_W-1:0] target,
    output logic              out_valid,
    output logic [DATA_W-1:0] result,
    output logic              zero_flag,
    output logic              ovf_flag
);
    shf_op_e           op_e;
    logic [DATA_W-1:0] sh_val;
    logic              sh_lost;
    logic [DATA_W-1:0] bf_val;
    logic [DATA_W-1:0] ex_val;
    shf_res_t          nxt;
    shf_res_t          cur;
    logic              vld_q;

    assign op_e = shf_op_e'(op);

    shf_shift_core #(.W(DATA_W), .AW(AMT_W)) u_shift (
        .operand (operand),
        .amount  (amount),
        .arith   (op_e == OP_ASH),
        .rotate  (op_e == OP_ROT),
        .value   (sh_val),
        .lost    (sh_lost)
    );

    shf_bitfield #(.W(DATA_W), .PW(POS_W)) u_field (
        .op      (op_e),
        .operand (operand),
        .target  (target),
        .fpos    (fpos),
        .flen    (flen),
        .value   (bf_val)
    );

    shf_exp_count #(.W(DATA_W)) u_exp (
        .operand (operand),
        .value   (ex_val)
    );

    always_comb begin
        nxt.ovf = 1'b0;
        case (op_e)
            OP_LSH, OP_ASH: begin
                nxt.value = sh_val;
                nxt.ovf   = sh_lost;
            end
            OP_ROT:  nxt.value = sh_val;
            OP_EXP:  nxt.value = ex_val;
            default: nxt.value = bf_val;
        endcase
        nxt.zero = (nxt.value == '0);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_q <= 1'b0;
            cur   <= '0;
        end else begin
            vld_q <= in_valid;
            if (in_valid) begin
                cur <= nxt;
            end
        end
    end

    assign out_valid = vld_q;
    assign result    = cur.value;
    assign zero_flag = cur.zero;
    assign ovf_flag  = cur.ovf;
endmodule

// File: rtl/shifter_unit_chk.sv
module shifter_unit_chk (
    input logic        clk,
    input logic        rst,
    input logic        in_valid,
    input logic [3:0]  op,
    input logic [7:0]  amount,
    input logic        out_valid,
    input logic [31:0] result,
    input logic        zero_flag,
    input logic        ovf_flag
);
    // R1
    valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    // R1
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> (!out_valid && $stable(result) && $stable(zero_flag) && $stable(ovf_flag)));

    // R6
    btst_upper_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op == 4'd6) |=> (result[31:1] == 31'd0));

    // R10
    zero_flag_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (zero_flag == (result == 32'd0)));

    // R11
    ovf_op_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op != 4'd0 && op != 4'd1) |=> !ovf_flag);

    // R11
    ovf_right_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && amount[7]) |=> !ovf_flag);

    // R12
    reset_state_chk: assert property (@(posedge clk)
        rst |=> (!out_valid && result == 32'd0 && !zero_flag && !ovf_flag));
endmodule

bind shifter_unit shifter_unit_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .op        (op),
    .amount    (amount),
    .out_valid (out_valid),
    .result    (result),
    .zero_flag (zero_flag),
    .ovf_flag  (ovf_flag)
);

// File: tb/shifter_unit_tb.sv
module shifter_unit_tb;
    localparam time CLK_P = 10ns;

    typedef struct {
        logic [31:0] res;
        logic        z;
        logic        o;
        string       tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [3:0]  op = '0;
    logic [31:0] operand = '0;
    logic [7:0]  amount = '0;
    logic [5:0]  fpos = '0;
    logic [5:0]  flen = '0;
    logic [31:0] target = '0;
    logic        out_valid;
    logic [31:0] result;
    logic        zero_flag;
    logic        ovf_flag;

    int   checks = 0;
    int   failures = 0;
    bit   done = 1'b0;
    exp_t sb[$];

    always #(CLK_P/2) clk = ~clk;

    shifter_unit u_dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .op(op),
        .operand(operand), .amount(amount), .fpos(fpos), .flen(flen),
        .target(target), .out_valid(out_valid), .result(result),
        .zero_flag(zero_flag), .ovf_flag(ovf_flag)
    );

    task automatic check(input bit ok, input string tag, input logic [33:0] act, input logic [33:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic send(input logic [3:0] o, input logic [31:0] a, input logic [7:0] amt,
                        input logic [5:0] p, input logic [5:0] l, input logic [31:0] t,
                        input logic [31:0] er, input logic eo, input string tag);
        exp_t e;
        @(negedge clk);
        in_valid = 1'b1; op = o; operand = a; amount = amt;
        fpos = p; flen = l; target = t;
        e.res = er; e.z = (er == 32'd0); e.o = eo; e.tag = tag;
        sb.push_back(e);
    endtask

    // monitor: compare each produced result against the scoreboard head
    always @(negedge clk) begin
        if (!rst && out_valid) begin
            if (sb.size() == 0) begin
                check(1'b0, "R1 unexpected out_valid", 34'(result), 34'd0);
            end else begin
                exp_t e;
                e = sb.pop_front();
                check({result, zero_flag, ovf_flag} == {e.res, e.z, e.o}, e.tag,
                      {result, zero_flag, ovf_flag}, {e.res, e.z, e.o});
            end
        end
    end

    task automatic finish_up();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        #(CLK_P * 100000);
        if (!done) begin
            check(1'b0, "watchdog expired", 34'd0, 34'd1);
            finish_up();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R12 reset state
        check({out_valid, result, zero_flag, ovf_flag} == 35'd0, "R12 reset state",
              {result, zero_flag, ovf_flag}, 34'd0);

        // R2 logical shift
        send(4'd0, 32'h0000_00F0, 8'd4,   6'd0, 6'd0, 32'd0, 32'h0000_0F00, 1'b0, "R2 lsh left 4");
        send(4'd0, 32'h8000_0001, 8'd1,   6'd0, 6'd0, 32'd0, 32'h0000_0002, 1'b1, "R11 lsh left loses bit");
        send(4'd0, 32'hF000_0000, 8'hFC,  6'd0, 6'd0, 32'd0, 32'h0F00_0000, 1'b0, "R2 lsh right 4 zero fill");
        send(4'd0, 32'h1234_5678, 8'd32,  6'd0, 6'd0, 32'd0, 32'h0000_0000, 1'b1, "R2 R10 R11 lsh left 32");
        // R3 arithmetic shift
        send(4'd1, 32'h8000_0000, 8'hFC,  6'd0, 6'd0, 32'd0, 32'hF800_0000, 1'b0, "R3 ash right sign fill");
        send(4'd1, 32'h8000_0000, 8'hD8,  6'd0, 6'd0, 32'd0, 32'hFFFF_FFFF, 1'b0, "R3 ash right 40");
        send(4'd1, 32'h4000_0000, 8'h80,  6'd0, 6'd0, 32'd0, 32'h0000_0000, 1'b0, "R3 ash right 128");
        send(4'd1, 32'h4000_0000, 8'd1,   6'd0, 6'd0, 32'd0, 32'h8000_0000, 1'b0, "R3 R11 ash left no loss");
        // R4 rotate
        send(4'd2, 32'h8000_0001, 8'd4,   6'd0, 6'd0, 32'd0, 32'h0000_0018, 1'b0, "R4 rotate left 4");
        send(4'd2, 32'h0000_0001, 8'hFF,  6'd0, 6'd0, 32'd0, 32'h8000_0000, 1'b0, "R4 rotate right 1");
        // R5 single-bit ops
        send(4'd3, 32'h0000_0000, 8'd0,   6'd31, 6'd0, 32'd0, 32'h8000_0000, 1'b0, "R5 set bit 31");
        send(4'd4, 32'hFFFF_FFFF, 8'd0,   6'd0,  6'd0, 32'd0, 32'hFFFF_FFFE, 1'b0, "R5 clear bit 0");
        send(4'd5, 32'h0000_0010, 8'd0,   6'd4,  6'd0, 32'd0, 32'h0000_0000, 1'b0, "R5 R10 toggle bit 4");
        // R6 bit test
        send(4'd6, 32'h0000_0100, 8'd0,   6'd8,  6'd0, 32'd0, 32'h0000_0001, 1'b0, "R6 test set bit");
        send(4'd6, 32'h0000_0100, 8'd0,   6'd9,  6'd0, 32'd0, 32'h0000_0000, 1'b0, "R6 test clear bit");
        // R7 extract
        send(4'd7, 32'hABCD_1234, 8'd0,   6'd8,  6'd8, 32'd0, 32'h0000_0012, 1'b0, "R7 extract mid field");
        send(4'd7, 32'h8000_0000, 8'd0,   6'd28, 6'd8, 32'd0, 32'h0000_0008, 1'b0, "R7 extract past top");
        send(4'd7, 32'hFFFF_FFFF, 8'd0,   6'd0,  6'd0, 32'd0, 32'h0000_0000, 1'b0, "R7 extract zero length");
        // R8 deposit
        send(4'd8, 32'h0000_00AB, 8'd0,   6'd4,  6'd8,  32'hFFFF_FFFF, 32'hFFFF_FABF, 1'b0, "R8 deposit mid");
        send(4'd8, 32'hFFFF_FFFF, 8'd0,   6'd28, 6'd8,  32'h0000_0000, 32'hF000_0000, 1'b0, "R8 deposit past top");
        send(4'd8, 32'h1234_5678, 8'd0,   6'd0,  6'd32, 32'hFFFF_FFFF, 32'h1234_5678, 1'b0, "R8 deposit full width");
        // R9 derive exponent
        send(4'd9, 32'h4000_0000, 8'd0,   6'd0, 6'd0, 32'd0, 32'h0000_0000, 1'b0, "R9 exp no redundant");
        send(4'd9, 32'h0000_0001, 8'd0,   6'd0, 6'd0, 32'd0, 32'hFFFF_FFE2, 1'b0, "R9 exp small positive");
        send(4'd9, 32'h0000_0000, 8'd0,   6'd0, 6'd0, 32'd0, 32'hFFFF_FFE1, 1'b0, "R9 exp zero");
        send(4'd9, 32'hFFFF_FFFF, 8'd0,   6'd0, 6'd0, 32'd0, 32'hFFFF_FFE1, 1'b0, "R9 exp minus one");
        send(4'd9, 32'hC000_0000, 8'd0,   6'd0, 6'd0, 32'd0, 32'hFFFF_FFFF, 1'b0, "R9 exp negative one redundant");

        // R1 idle: inputs change but in_valid is low
        @(negedge clk);
        in_valid = 1'b0; op = 4'd0; operand = 32'h0000_0001; amount = 8'd0;
        repeat (3) @(negedge clk);
        check(!out_valid && result == 32'hFFFF_FFFF && !zero_flag && !ovf_flag,
              "R1 idle hold", {result, zero_flag, ovf_flag}, {32'hFFFF_FFFF, 2'b00});
        check(sb.size() == 0, "R1 every item returned", 34'(sb.size()), 34'd0);
        done = 1'b1;
        finish_up();
    end
endmodule